// File: doc/BRIEF.md
# Synchronous Serial Receiver with Watermark FIFO

This block is the receive half of a synchronous serial port. The serial clock and serial data are synchronous to the system clock. The block samples the data line on each rising edge of the serial clock and assembles the bits into a word. Each finished word is pushed into a 16-entry receive FIFO. A host drains the FIFO through a simple read port that returns the data one cycle after the strobe.

Words can be framed in two ways. In framed mode a sync pulse marks the first bit of each word, and the line may idle between words. In continuous mode words follow one another with no gap and no sync. Bit order and word length (8 or 16 bits) are selectable. The ready flag compares the FIFO fill level against a programmable 4-bit watermark, so the host can wait until several words are present.

Top module: `sync_ser_rx`

## Requirements
- R1: After reset, `fill` is 0, `ready` is 0, `overrun` is 0 and `rd_data` is 0.
- R2: With `framed`=1, a word starts on a rising `sck` edge where `sync` is 1, and that edge carries the word's first bit. Bits on rising edges outside a word are ignored. A `sync` pulse seen while a word is in progress is ignored.
- R3: With `framed`=0, words arrive back to back. The first bit of the next word is taken on the rising `sck` edge right after the previous word's last bit. The first word begins on the first rising edge after reset or after a configuration change.
- R4: With `lsb_first`=1, the first received bit lands in bit 0 of the word and later bits fill bits 1, 2 and so on upward.
- R5: With `lsb_first`=0, the first received bit lands in the word's top bit (bit 7 for 8-bit words, bit 15 for 16-bit words) and later bits fill downward.
- R6: `wide`=0 selects 8-bit words, which appear in `rd_data[7:0]` with `rd_data[15:8]`=0. `wide`=1 selects 16-bit words.
- R7: Data is captured only on rising `sck` edges. Holding `sck` high for several clocks captures one bit. A word's `fill` increment is visible two `clk` edges after the edge on which its last bit's rising `sck` is seen.
- R8: `rd_en` with a non-empty FIFO puts the oldest word on `rd_data` at the next `clk` edge and lowers `fill` by one. `rd_en` with an empty FIFO changes neither `fill` nor `rd_data`.
- R9: The FIFO holds 16 words. A word arriving while `fill` is 16 is dropped, and `overrun` becomes 1 and stays 1 until reset.
- R10: `ready` is 1 exactly when `fill` is greater than or equal to `watermark`. It changes on the same clock edge as `fill`, so it drops as soon as reads take `fill` below the watermark.
- R11: A change of `framed`, `lsb_first` or `wide` discards any partly assembled word. The next captured bit is bit 0 of a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| sdi | input | 1 | Serial data |
| sync | input | 1 | Word start pulse (framed mode) |
| framed | input | 1 | 1 = sync-framed words, 0 = continuous words |
| lsb_first | input | 1 | 1 = first bit to bit 0, 0 = first bit to top bit |
| wide | input | 1 | 0 = 8-bit words, 1 = 16-bit words |
| watermark | input | 4 | Fill level at which ready asserts |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Word read from the FIFO |
| fill | output | 5 | Number of words in the FIFO |
| ready | output | 1 | fill >= watermark |
| overrun | output | 1 | Sticky flag: a word was dropped |

## Verification
A bit counter that is off by one shows up as rotated or shifted words on the very next read. In continuous mode it also corrupts every word after it, so back-to-back checks expose it within two words. A wrong FIFO pointer or count shows as a wrong `fill`, or as stale data on the read after the word is pushed. A wrong threshold compare shows as `ready` out of step with `fill` on the same edge. A missed full check shows up only at the sixteenth and seventeenth words, as a missing `overrun` or a wrapped first word.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef struct packed {
    logic framed;
    logic lsb_first;
    logic wide;
  } rx_cfg_t;
endpackage

// File: rtl/ssr_deser.sv
module ssr_deser
  import ssr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              sdi,
  input  logic              sync,
  input  rx_cfg_t           cfg,
  output logic              push,
  output logic [DATA_W-1:0] word
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_W = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(NARROW_W - 1);

  logic              sck_q;
  rx_cfg_t           cfg_q;
  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;

  logic              rise, cfg_chg, take, done;
  logic [CNT_W-1:0]  last, idx;
  logic [DATA_W-1:0] sh_nxt;

  always_comb begin
    rise    = sck & ~sck_q;
    cfg_chg = (cfg != cfg_q);
    last    = cfg.wide ? LAST_W : LAST_N;
    // framed words open only on a sync edge; continuous mode always takes
    take    = rise & (~cfg.framed | active | sync);
    idx     = cfg.lsb_first ? cnt : (last - cnt);
    sh_nxt  = (cnt == '0) ? '0 : shreg;
    sh_nxt[idx] = sdi;
    done    = take & (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b0;
      cfg_q  <= '0;
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      push   <= 1'b0;
      word   <= '0;
    end else begin
      sck_q <= sck;
      cfg_q <= cfg;
      push  <= 1'b0;
      if (cfg_chg) begin
        cnt    <= '0;
        active <= 1'b0;
      end else if (take) begin
        shreg <= sh_nxt;
        if (done) begin
          cnt    <= '0;
          active <= 1'b0;
          push   <= 1'b1;
          word   <= sh_nxt;
        end else begin
          cnt    <= cnt + 1'b1;
          active <= 1'b1;
        end
      end
    end
  end

  // R7: a word is only pushed after a rising serial clock edge was detected
  a_r7_push_after_rise: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(sck & ~sck_q));
  // R6: narrow words never carry upper bits
  a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (push && !$past(cfg.wide)) |-> (word[DATA_W-1:NARROW_W] == '0));
endmodule

// File: rtl/ssr_fifo.sv
module ssr_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] thresh,
  output logic [W-1:0]  rd_data,
  output logic [AW:0]   count,
  output logic          ready,
  output logic          overrun
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, empty, do_wr, do_rd;
  logic [AW:0]   count_nxt;

  always_comb begin
    full      = (count == (AW+1)'(DEPTH));
    empty     = (count == '0);
    do_wr     = wr_en & ~full;
    do_rd     = rd_en & ~empty;
    count_nxt = count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (do_rd) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      ready   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      count <= count_nxt;
      ready <= (count_nxt >= {1'b0, thresh});
      if (wr_en && full) overrun <= 1'b1;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= ~rst;

  // R9: the fill level never exceeds the depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  // R9: a write into a full FIFO with no read leaves it full and flags overrun
  a_r9_full_drop: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (count == (AW+1)'(DEPTH)) && overrun);
  // R9: overrun is sticky
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  // R8: reading an empty FIFO with no write keeps it empty and data stable
  a_r8_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !wr_en) |=> (count == '0) && $stable(rd_data));
  // R10: ready tracks the fill level against the watermark
  a_r10_ready_level: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (ready == (count >= {1'b0, $past(thresh)})));
endmodule

// File: rtl/sync_ser_rx.sv
module sync_ser_rx
  import ssr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int DEPTH    = 16,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              sdi,
  input  logic              sync,
  input  logic              framed,
  input  logic              lsb_first,
  input  logic              wide,
  input  logic [AW-1:0]     watermark,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [AW:0]       fill,
  output logic              ready,
  output logic              overrun
);
  rx_cfg_t           cfg;
  logic              push;
  logic [DATA_W-1:0] word;

  always_comb begin
    cfg.framed    = framed;
    cfg.lsb_first = lsb_first;
    cfg.wide      = wide;
  end

  ssr_deser #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_deser (
    .clk(clk), .rst(rst), .sck(sck), .sdi(sdi), .sync(sync),
    .cfg(cfg), .push(push), .word(word)
  );

  ssr_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(push), .wr_data(word), .rd_en(rd_en),
    .thresh(watermark), .rd_data(rd_data), .count(fill), .ready(ready),
    .overrun(overrun)
  );
endmodule

// File: tb/sim_sync_ser_rx.sv
module sim_sync_ser_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0, sdi = 1'b0, sync = 1'b0;
  logic        framed = 1'b0, lsb_first = 1'b0, wide = 1'b0;
  logic [3:0]  watermark = 4'd1;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic [4:0]  fill;
  logic        ready, overrun;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sync_ser_rx u0 (
    .clk(clk), .rst(rst), .sck(sck), .sdi(sdi), .sync(sync),
    .framed(framed), .lsb_first(lsb_first), .wide(wide),
    .watermark(watermark), .rd_en(rd_en), .rd_data(rd_data),
    .fill(fill), .ready(ready), .overrun(overrun)
  );

  // {framed, lsb_first, wide, data}
  localparam logic [18:0] VEC [6] = '{
    {3'b110, 16'h00A5}, {3'b100, 16'h0037}, {3'b111, 16'hC3E1},
    {3'b011, 16'h8001}, {3'b000, 16'h00B4}, {3'b101, 16'h5A96}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic s, input int hi);
    @(negedge clk); sdi = b; sync = s; sck = 1'b1;
    repeat (hi) @(posedge clk);
    @(negedge clk); sck = 1'b0; sync = 1'b0; sdi = ~b;
    @(posedge clk);
  endtask

  task automatic send_word(input logic [15:0] d, input logic lsb, input logic wd,
                           input logic with_sync, input int hi);
    int n = wd ? 16 : 8;
    for (int i = 0; i < n; i++)
      send_bit(lsb ? d[i] : d[n-1-i], with_sync && (i == 0), hi);
  endtask

  task automatic set_cfg(input logic fr, input logic lsb, input logic wd);
    @(negedge clk); framed = fr; lsb_first = lsb; wide = wd;
    repeat (2) @(posedge clk);
  endtask

  task automatic read_word();
    @(negedge clk); rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 fill", 32'(fill), 0);
    chk("R1 ready", 32'(ready), 0);
    chk("R1 overrun", 32'(overrun), 0);
    chk("R1 rd_data", 32'(rd_data), 0);

    // vector table: each entry is one word in its configuration
    for (int v = 0; v < 6; v++) begin
      logic fr, lsb, wd;
      logic [15:0] d, exp;
      {fr, lsb, wd, d} = VEC[v];
      set_cfg(fr, lsb, wd);
      if (fr) begin
        send_bit(1'b1, 1'b0, 1);   // R2: idle bits outside a frame
        send_bit(1'b1, 1'b0, 1);
      end
      send_word(d, lsb, wd, fr, 1);
      @(negedge clk);
      chk(fr ? "R2 fill after framed word" : "R3 fill after word", 32'(fill), 1);
      read_word();
      exp = wd ? d : {8'h00, d[7:0]};
      chk(lsb ? "R4 R6 word" : "R5 R6 word", 32'(rd_data), 32'(exp));
      chk("R8 fill after read", 32'(fill), 0);
    end

    // R8: read of empty FIFO changes nothing
    read_word();
    chk("R8 empty read data", 32'(rd_data), 32'h5A96);
    chk("R8 empty read fill", 32'(fill), 0);

    // R2: sync during an active word is ignored
    set_cfg(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) send_bit(1'(8'h6C >> i), (i == 0) || (i == 3), 1);
    @(negedge clk);
    chk("R2 fill mid-frame sync", 32'(fill), 1);
    read_word();
    chk("R2 mid-frame sync ignored", 32'(rd_data), 32'h006C);

    // R3: two continuous words back to back, MSB first
    set_cfg(1'b0, 1'b0, 1'b0);
    send_word(16'h00D2, 1'b0, 1'b0, 1'b0, 1);
    send_word(16'h004B, 1'b0, 1'b0, 1'b0, 1);
    @(negedge clk);
    chk("R3 fill two words", 32'(fill), 2);
    read_word();
    chk("R3 first word", 32'(rd_data), 32'h00D2);
    read_word();
    chk("R3 second word", 32'(rd_data), 32'h004B);

    // R7: long serial clock high phase captures one bit per rise
    send_word(16'h0071, 1'b0, 1'b0, 1'b0, 3);
    @(negedge clk);
    chk("R7 fill long high", 32'(fill), 1);
    read_word();
    chk("R7 long high word", 32'(rd_data), 32'h0071);

    // R11: partial word is dropped on config change
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0, 1);
    set_cfg(1'b0, 1'b0, 1'b1);
    send_word(16'h1234, 1'b0, 1'b1, 1'b0, 1);
    @(negedge clk);
    chk("R11 fill after restart", 32'(fill), 1);
    read_word();
    chk("R11 restarted word", 32'(rd_data), 32'h1234);

    // R10: watermark of 3
    set_cfg(1'b0, 1'b1, 1'b0);
    @(negedge clk); watermark = 4'd3;
    send_word(16'h0001, 1'b1, 1'b0, 1'b0, 1);
    send_word(16'h0002, 1'b1, 1'b0, 1'b0, 1);
    @(negedge clk);
    chk("R10 ready below watermark", 32'(ready), 0);
    send_word(16'h0003, 1'b1, 1'b0, 1'b0, 1);
    @(negedge clk);
    chk("R10 ready at watermark", 32'(ready), 1);
    read_word();
    chk("R10 ready drops after read", 32'(ready), 0);
    read_word();
    read_word();
    chk("R10 drained", 32'(fill), 0);

    // R9: overflow with 17 words
    @(negedge clk); watermark = 4'd15;
    for (int k = 0; k < 17; k++) begin
      send_word(16'(k * 8'h11 + 1), 1'b1, 1'b0, 1'b0, 1);
      if (k == 14) begin
        @(negedge clk);
        chk("R10 ready at fill 15", 32'(ready), 1);
      end
    end
    @(negedge clk);
    chk("R9 fill capped", 32'(fill), 16);
    chk("R9 overrun set", 32'(overrun), 1);
    read_word();
    chk("R9 oldest word kept", 32'(rd_data), 32'h0001);
    chk("R9 overrun sticky", 32'(overrun), 1);
    chk("R10 ready at 15", 32'(ready), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule